// File: doc/BRIEF.md
# Pulse Width Measurement Timer

A single timer channel that measures for how long an input pin stays at a chosen level. Software arms the channel with a start strobe. The channel then waits for the edge that begins the selected level. From that edge it counts up on every enabled count-clock cycle, and it captures the count at the opposite edge. Each capture also produces a one-cycle interrupt pulse and rewrites an overflow flag. The channel re-arms by itself after each capture, so a stream of pulses is measured one after another until a stop strobe returns it to idle.

The pin passes through a synchronizer chain. It is then sampled only in cycles where the count-clock enable is high. For this reason a measured width can be off by up to one count-clock period. The true width in count-clock periods is `65536 * ovf_flag + cap_value + 1` at the default width. More generally it is `2**CNT_W * ovf_flag + cap_value + 1`.

Top module: `pulse_width_meter`

## Requirements
- R1: After reset, a `start_req` pulse while `chan_en` is 0 sets `chan_en` to 1 at the next clock edge. The channel then waits for a start edge and performs no capture before one is seen.
- R2: With `mode_sel` = 2'b11 the channel measures the high level. A rising pin edge starts the count and a falling pin edge captures it.
- R3: With `mode_sel` = 2'b10 the channel measures the low level. A falling pin edge starts the count and a rising pin edge captures it.
- R4: With `mode_sel` = 2'b00 or 2'b01 no pin edge starts a measurement, so no capture occurs.
- R5: At the start edge the count restarts from zero. At the capture edge `cap_value` takes the count, which equals the number of sampled cycles at the measured level minus one. `cap_irq` is high for exactly the one cycle in which the new `cap_value` first appears.
- R6: Each capture rewrites `ovf_flag`. The flag is 1 if the count wrapped past its all-ones value during that measurement, however many times it wrapped, and 0 otherwise.
- R7: After a capture the counter holds at `cap_value + 1` and the channel returns to waiting for a start edge. The next pulse is measured without a new `start_req`.
- R8: A `start_req` while `chan_en` is 1 has no effect. A measurement in progress completes with an unchanged result.
- R9: A `stop_req` clears `chan_en` at the next edge and returns the channel to idle. It leaves `cap_value` and `ovf_flag` unchanged. Stop takes priority over a simultaneous start.
- R10: The pin is sampled and the counter advances only in cycles with `cnt_en` high. Cycles with `cnt_en` low are not counted, and pin activity that falls entirely within them goes unseen.
- R11: During and right after reset, `cap_value`, `ovf_flag`, `chan_en` and `cap_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count-clock enable; one count tick per high cycle |
| pin_in | input | 1 | Asynchronous signal being measured |
| start_req | input | 1 | Arms the channel (one-cycle strobe) |
| stop_req | input | 1 | Disarms the channel (one-cycle strobe) |
| mode_sel | input | 2 | 2'b11 high width, 2'b10 low width, others inert |
| cap_value | output | CNT_W | Last captured count |
| ovf_flag | output | 1 | Wrap status of the last capture |
| chan_en | output | 1 | Channel armed |
| cap_irq | output | 1 | One-cycle capture interrupt |

## Verification
Several properties are checked on every cycle. The interrupt lasts one cycle and coincides with the only cycles in which `cap_value` changes. The counter is frozen at `cap_value + 1` while the channel waits. A stop always clears `chan_en` and leaves the results unchanged. A start while armed never disarms the channel. Only the bench's scenarios can show the measured values themselves: exact widths in both polarities, the overflow boundary at exactly one full count versus one past it, cycles removed by a gated count enable, and the absence of captures in inert modes.

// File: rtl/pwmeas_pkg.sv
package pwmeas_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_WAIT  = 2'b01,
      ST_COUNT = 2'b10
   } pwmeas_state_e;

   localparam logic [1:0] MODE_LOW_WIDTH  = 2'b10;
   localparam logic [1:0] MODE_HIGH_WIDTH = 2'b11;

endpackage

// File: rtl/pwmeas_edge.sv
module pwmeas_edge #(
   parameter int SYNC_STAGES = 2,
   parameter bit RST_LEVEL   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_en,
   input  logic pin_in,
   output logic rise,
   output logic fall
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   smp_q;
   logic                   sync_out;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pwmeas_edge: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= {SYNC_STAGES{RST_LEVEL}};
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      end
   end

   assign sync_out = sync_q[SYNC_STAGES-1];

   // Sampled level only advances on count-clock ticks.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q <= RST_LEVEL;
      end else if (smp_en) begin
         smp_q <= sync_out;
      end
   end

   assign rise = smp_en &  sync_out & ~smp_q;
   assign fall = smp_en & ~sync_out &  smp_q;

endmodule

// File: rtl/pwmeas_counter.sv
module pwmeas_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_zero,
   input  logic             step,
   output logic [CNT_W-1:0] count,
   output logic             wrapped
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '0;
         wrapped <= 1'b0;
      end else if (load_zero) begin
         count   <= '0;
         wrapped <= 1'b0;
      end else if (step) begin
         count <= count + CNT_ONE;
         if (count == CNT_MAX) begin
            wrapped <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/pwmeas_ctrl.sv
module pwmeas_ctrl
   import pwmeas_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cnt_en,
   input  logic          start_req,
   input  logic          stop_req,
   input  logic [1:0]    mode_sel,
   input  logic          pin_rise,
   input  logic          pin_fall,
   output pwmeas_state_e state,
   output logic          load_zero,
   output logic          step,
   output logic          cap_fire
);

   pwmeas_state_e st_next;
   logic          mode_valid;
   logic          edge_begin;
   logic          edge_end;

   assign mode_valid = mode_sel[1];
   assign edge_begin = mode_valid & (mode_sel[0] ? pin_rise : pin_fall);
   assign edge_end   = mode_valid & (mode_sel[0] ? pin_fall : pin_rise);

   always_comb begin
      st_next   = state;
      load_zero = 1'b0;
      step      = 1'b0;
      cap_fire  = 1'b0;
      if (stop_req) begin
         st_next = ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start_req) st_next = ST_WAIT;
            end
            ST_WAIT: begin
               if (edge_begin) begin
                  load_zero = 1'b1;
                  st_next   = ST_COUNT;
               end
            end
            ST_COUNT: begin
               if (cnt_en) begin
                  step = 1'b1;
                  if (edge_end) begin
                     cap_fire = 1'b1;
                     st_next  = ST_WAIT;
                  end
               end
            end
            default: st_next = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= st_next;
   end

endmodule

// File: rtl/pulse_width_meter.sv
module pulse_width_meter
   import pwmeas_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit PIN_RST_LVL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             pin_in,
   input  logic             start_req,
   input  logic             stop_req,
   input  logic [1:0]       mode_sel,
   output logic [CNT_W-1:0] cap_value,
   output logic             ovf_flag,
   output logic             chan_en,
   output logic             cap_irq
);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("pulse_width_meter: CNT_W must be at least 2");
      end
   endgenerate

   logic             pin_rise;
   logic             pin_fall;
   logic             load_zero;
   logic             step;
   logic             cap_fire;
   logic [CNT_W-1:0] cnt_q;
   logic             wrap_q;
   pwmeas_state_e    st_q;

   pwmeas_edge #(
      .SYNC_STAGES (SYNC_STAGES),
      .RST_LEVEL   (PIN_RST_LVL)
   ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_en (cnt_en),
      .pin_in (pin_in),
      .rise   (pin_rise),
      .fall   (pin_fall)
   );

   pwmeas_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_en    (cnt_en),
      .start_req (start_req),
      .stop_req  (stop_req),
      .mode_sel  (mode_sel),
      .pin_rise  (pin_rise),
      .pin_fall  (pin_fall),
      .state     (st_q),
      .load_zero (load_zero),
      .step      (step),
      .cap_fire  (cap_fire)
   );

   pwmeas_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_zero (load_zero),
      .step      (step),
      .count     (cnt_q),
      .wrapped   (wrap_q)
   );

   // Capture register, status flag and interrupt update on the same edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_value <= '0;
         ovf_flag  <= 1'b0;
         cap_irq   <= 1'b0;
      end else begin
         cap_irq <= cap_fire;
         if (cap_fire) begin
            cap_value <= cnt_q;
            ovf_flag  <= wrap_q;
         end
      end
   end

   assign chan_en = (st_q != ST_IDLE);

endmodule

// File: rtl/pwmeas_checker.sv
module pwmeas_checker
   import pwmeas_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_en,
   input logic             start_req,
   input logic             stop_req,
   input logic [CNT_W-1:0] cap_value,
   input logic             ovf_flag,
   input logic             chan_en,
   input logic             cap_irq,
   input pwmeas_state_e    state,
   input logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   // R5: interrupt is a single-cycle pulse
   a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      cap_irq |=> !cap_irq);

   // R5: the captured value only moves together with the interrupt
   a_r5_cap_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_irq |-> ($stable(cap_value) && $stable(ovf_flag)));

   // R7: right after capture the counter sits at capture plus one
   a_r7_hold_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
      cap_irq |-> (count == cap_value + ONE));

   // R7: counter frozen while waiting for a start edge
   a_r7_frozen_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && !cnt_en) |=> $stable(count));

   // R8: start while armed never disarms
   a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && start_req && !stop_req) |=> chan_en);

   // R9: stop disarms and keeps results
   a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> (!chan_en && $stable(cap_value) && $stable(ovf_flag)));

   // R1: start from idle arms the channel
   a_r1_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (!chan_en && start_req && !stop_req) |=> (chan_en && state == ST_WAIT));

   // R9: no interrupt can appear on a disarmed channel
   a_r9_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      cap_irq |-> chan_en);

endmodule

bind pulse_width_meter pwmeas_checker #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt_en    (cnt_en),
   .start_req (start_req),
   .stop_req  (stop_req),
   .cap_value (cap_value),
   .ovf_flag  (ovf_flag),
   .chan_en   (chan_en),
   .cap_irq   (cap_irq),
   .state     (st_q),
   .count     (cnt_q)
);

// File: tb/pulse_width_meter_test.sv
module pulse_width_meter_test;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 195000;
   localparam int NVEC       = 6;

   // Vector table: polarity (1 = high width), width in clocks, expected capture.
   localparam bit VHI [NVEC] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
   localparam int VW  [NVEC] = '{1, 5, 37, 200, 3, 100};
   localparam int VE  [NVEC] = '{0, 4, 36, 199, 2, 99};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b1;
   logic        pin_in = 1'b0;
   logic        start_req = 1'b0;
   logic        stop_req = 1'b0;
   logic [1:0]  mode_sel = 2'b11;
   logic [15:0] cap_value;
   logic        ovf_flag;
   logic        chan_en;
   logic        cap_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   pulse_width_meter uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_en    (cnt_en),
      .pin_in    (pin_in),
      .start_req (start_req),
      .stop_req  (stop_req),
      .mode_sel  (mode_sel),
      .cap_value (cap_value),
      .ovf_flag  (ovf_flag),
      .chan_en   (chan_en),
      .cap_irq   (cap_irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic pulse(input bit hi, input int w);
      pin_in = hi;
      repeat (w) @(negedge clk);
      pin_in = ~hi;
   endtask

   task automatic wait_irq(input int limit, output bit seen);
      seen = 0;
      for (int i = 0; i < limit && !seen; i++) begin
         @(negedge clk);
         if (cap_irq) seen = 1;
      end
   endtask

   task automatic expect_capture(input string req, input int exp_cap,
                                 input bit exp_ovf, input int limit);
      bit seen;
      wait_irq(limit, seen);
      check(req, "capture seen", seen, 1);
      check(req, "cap_value", cap_value, exp_cap);
      check(req, "ovf_flag", ovf_flag, exp_ovf);
      @(negedge clk);
      check("R5", "irq width one cycle", cap_irq, 0);
   endtask

   task automatic strobe(input bit is_start, input bit is_stop);
      start_req = is_start;
      stop_req  = is_stop;
      @(negedge clk);
      start_req = 1'b0;
      stop_req  = 1'b0;
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      bit seen;
      logic [15:0] kept;

      repeat (3) @(negedge clk);
      check("R11", "cap_value in reset", cap_value, 0);
      check("R11", "ovf_flag in reset", ovf_flag, 0);
      check("R11", "chan_en in reset", chan_en, 0);
      check("R11", "cap_irq in reset", cap_irq, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R11", "chan_en after reset", chan_en, 0);

      // R1: arm, then no capture while pin is quiet
      strobe(1'b1, 1'b0);
      check("R1", "chan_en after start", chan_en, 1);
      wait_irq(10, seen);
      check("R1", "no capture before start edge", seen, 0);

      // Vector table: R2 high widths, R3 low widths, R7 re-arm without start
      for (int v = 0; v < NVEC; v++) begin
         mode_sel = VHI[v] ? 2'b11 : 2'b10;
         pin_in   = ~VHI[v];
         repeat (6) @(negedge clk);
         pulse(VHI[v], VW[v]);
         expect_capture(VHI[v] ? "R2" : "R3", VE[v], 1'b0, 20);
         check("R7", "still armed after capture", chan_en, 1);
      end

      // R8: start during a measurement leaves the result unchanged
      mode_sel = 2'b11;
      pin_in   = 1'b0;
      repeat (6) @(negedge clk);
      pin_in = 1'b1;
      repeat (4) @(negedge clk);
      strobe(1'b1, 1'b0);
      repeat (7) @(negedge clk);
      pin_in = 1'b0;
      expect_capture("R8", 11, 1'b0, 20);
      check("R8", "chan_en after extra start", chan_en, 1);

      // R4: inert mode codes
      for (int m = 0; m < 2; m++) begin
         mode_sel = m[1:0];
         repeat (4) @(negedge clk);
         pulse(1'b1, 10);
         wait_irq(20, seen);
         check("R4", "no capture in inert mode", seen, 0);
         pin_in = 1'b1;
         repeat (4) @(negedge clk);
         pulse(1'b0, 10);
         wait_irq(20, seen);
         check("R4", "no capture in inert mode (low)", seen, 0);
         pin_in = 1'b0;
         mode_sel = 2'b00;
         repeat (4) @(negedge clk);
      end

      // R10: gated count enable removes cycles from the count
      mode_sel = 2'b11;
      repeat (6) @(negedge clk);
      pin_in = 1'b1;
      repeat (5) @(negedge clk);
      cnt_en = 1'b0;
      repeat (10) @(negedge clk);
      cnt_en = 1'b1;
      repeat (15) @(negedge clk);
      pin_in = 1'b0;
      expect_capture("R10", 19, 1'b0, 20);

      // R10: a pulse entirely inside disabled cycles is unseen
      kept   = cap_value;
      cnt_en = 1'b0;
      repeat (4) @(negedge clk);
      pulse(1'b1, 10);
      repeat (6) @(negedge clk);
      cnt_en = 1'b1;
      wait_irq(20, seen);
      check("R10", "no capture while disabled", seen, 0);
      check("R10", "cap_value kept", cap_value, kept);

      // R9: stop clears enable, keeps results, blocks captures
      kept = cap_value;
      strobe(1'b0, 1'b1);
      check("R9", "chan_en after stop", chan_en, 0);
      pulse(1'b1, 8);
      wait_irq(20, seen);
      check("R9", "no capture after stop", seen, 0);
      check("R9", "cap_value kept", cap_value, kept);
      check("R9", "ovf_flag kept", ovf_flag, 0);
      strobe(1'b1, 1'b1);
      check("R9", "stop wins over start", chan_en, 0);
      strobe(1'b1, 1'b0);
      check("R1", "re-armed by start", chan_en, 1);

      // R6: overflow boundary and rewrite
      repeat (4) @(negedge clk);
      pulse(1'b1, 65536);
      expect_capture("R6", 16'hFFFF, 1'b0, 20);
      repeat (4) @(negedge clk);
      pulse(1'b1, 65537);
      expect_capture("R6", 0, 1'b1, 20);
      repeat (4) @(negedge clk);
      pulse(1'b1, 4);
      expect_capture("R6", 3, 1'b0, 20);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule